// File: doc/BRIEF.md
# Host Keyboard Controller Command Engine

This block is the host-facing half of a PC-style keyboard controller. The host sees two byte-wide addresses. Writing the data address hands a byte to the controller. Writing the command address hands an opcode to the controller. Reading the data address collects a result byte. Reading the command address returns a status byte. Behind these addresses the block keeps an input buffer and an output buffer, a small scratch RAM whose byte 0 is the configuration byte, and an 8-bit system output port. Bit 0 of that port is the system reset line and bit 1 is the A20 gate. An external input port can also be read.

Each byte the host writes is consumed by a command engine one cycle after it lands. Opcodes fall into classes:
- RAM read and RAM write, with the RAM address taken from the low opcode bits.
- Output-port nibble load.
- Port enables and port disables.
- Self-tests.
- Port reads and port writes.
- A20 control.
- Timed low pulses on output-port bits 0 to 3.

Two opcodes take an argument. The next byte written to the data address is consumed as that argument. A data byte that arrives with no argument pending is passed on as a byte for the keyboard. While a pulse is running, the engine consumes nothing. The pending byte waits and the host sees IBF stay high.

Top module: `kbc_cmd_engine`

## Requirements
- R1: After reset the status byte reads 00h, the system port reads PORT_RESET (default 01h), the kbd_disabled and aux_disabled outputs are 0, and kbd_tx_valid is 0.
- R2: Status bits 1 and 3 track host writes.
  - Bit 1 (IBF) reads 1 in the cycle after a host write to either address, and reads 0 one cycle later when no pulse is running.
  - Bit 3 reads 1 if the last write went to the command address and 0 if it went to the data address.
- R3: Opcodes 20h–3Fh place RAM[opcode[4:0]] in the output buffer and set status bit 0 (OBF). A host read of the data address returns that byte and clears OBF.
- R4: Opcodes 60h–7Fh store the next data-address byte into RAM[opcode[4:0]]. Status bit 2 always equals bit 2 of RAM byte 0.
- R5: Opcodes 90h–9Fh copy opcode[3:0] into system port bits 3:0 and leave bits 7:4 unchanged.
- R6: System port access and A20 control.
  - D0h returns the system port value.
  - D1h loads the next data byte into the system port.
  - DDh clears port bit 1 and DFh sets it.
  - The port does not change in a cycle with no consumed byte and no running pulse.
- R7: Self-test results.
  - AAh returns 55h when selftest_ok is 1 and FCh when it is 0.
  - ABh returns kbd_link_code zero-extended to 8 bits.
  - A9h returns aux_link_code zero-extended to 8 bits.
- R8: Configuration bits and their outputs.
  - ADh sets configuration bit 4 and AEh clears it. kbd_disabled equals that bit.
  - A7h sets configuration bit 5 and A8h clears it. aux_disabled equals that bit.
- R9: Opcode C0h returns the in_port value.
- R10: For opcodes F0h–FFh, each system port bit among 0–3 whose opcode bit is 0 reads 0 for exactly PULSE_CYCLES cycles. The bit then returns to its stored value. Bits whose opcode bit is 1 are unaffected.
- R11: While a pulse is running, a newly written byte is not consumed and IBF stays 1. The byte is executed once the pulse ends.
- R12: A data byte written with no argument pending produces a one-cycle kbd_tx_valid with kbd_tx_data equal to that byte. An argument byte produces none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_sel_cmd | input | 1 | 1 selects the command/status address, 0 the data address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Status byte or output buffer, per host_sel_cmd |
| in_port | input | 8 | External input port sampled by C0h |
| selftest_ok | input | 1 | Internal self-test verdict used by AAh |
| kbd_link_code | input | 3 | Keyboard interface test code (0 ok, 1–4 stuck line) |
| aux_link_code | input | 3 | Auxiliary interface test code |
| sys_port | output | 8 | System output port with pulses applied; bit 0 reset, bit 1 A20 |
| kbd_disabled | output | 1 | Configuration bit 4 |
| aux_disabled | output | 1 | Configuration bit 5 |
| kbd_tx_valid | output | 1 | One-cycle strobe for a byte bound to the keyboard |
| kbd_tx_data | output | 8 | Byte bound to the keyboard |

## Verification
A wrong internal state becomes visible at the ports within a command or two.

- **Engine state.** If a lost or stale argument-pending state is left behind, the next data byte shows up on kbd_tx_valid when it should land in RAM or in the port, or the reverse. A later 20h read or a D0h read exposes it.
- **Pulse counter.** A miscounting pulse counter shows up on sys_port as a low window of the wrong length. It can also show as IBF clearing while a pulse is still running.
- **RAM and configuration byte.** A corrupted RAM byte or configuration bit appears at once on status bit 2 or on the disable outputs. Otherwise it appears on the next RAM read.

// File: rtl/kbc_pkg.sv
package kbc_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_RAM_ARG,
    ENG_PORT_ARG
  } eng_state_e;

  typedef enum logic [4:0] {
    OP_NONE,
    OP_RD_RAM,
    OP_WR_RAM,
    OP_PORT_NIB,
    OP_AUX_OFF,
    OP_AUX_ON,
    OP_AUX_TEST,
    OP_SELF_TEST,
    OP_KBD_TEST,
    OP_KBD_OFF,
    OP_KBD_ON,
    OP_RD_IN,
    OP_RD_OUT,
    OP_WR_OUT,
    OP_A20_OFF,
    OP_A20_ON,
    OP_PULSE
  } op_class_e;

  localparam int CFG_SYS_BIT = 2;
  localparam int CFG_KBD_BIT = 4;
  localparam int CFG_AUX_BIT = 5;
  localparam int PORT_A20_BIT = 1;

  function automatic op_class_e classify_op(input logic [7:0] op);
    op_class_e c;
    casez (op)
      8'b001?_????: c = OP_RD_RAM;
      8'b011?_????: c = OP_WR_RAM;
      8'b1001_????: c = OP_PORT_NIB;
      8'hA7:        c = OP_AUX_OFF;
      8'hA8:        c = OP_AUX_ON;
      8'hA9:        c = OP_AUX_TEST;
      8'hAA:        c = OP_SELF_TEST;
      8'hAB:        c = OP_KBD_TEST;
      8'hAD:        c = OP_KBD_OFF;
      8'hAE:        c = OP_KBD_ON;
      8'hC0:        c = OP_RD_IN;
      8'hD0:        c = OP_RD_OUT;
      8'hD1:        c = OP_WR_OUT;
      8'hDD:        c = OP_A20_OFF;
      8'hDF:        c = OP_A20_ON;
      8'b1111_????: c = OP_PULSE;
      default:      c = OP_NONE;
    endcase
    return c;
  endfunction

  // Bits whose opcode bit is 0 get pulsed low.
  function automatic logic [3:0] pulse_mask_of(input logic [7:0] op);
    return ~op[3:0];
  endfunction

  function automatic logic [7:0] selftest_code(input logic ok);
    return ok ? 8'h55 : 8'hFC;
  endfunction

  function automatic logic [7:0] status_compose(input logic last_cmd, input logic sys_flag,
                                                input logic ibf, input logic obf);
    return {4'b0000, last_cmd, sys_flag, ibf, obf};
  endfunction

endpackage

// File: rtl/kbc_host_if.sv
module kbc_host_if
  import kbc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic       host_sel_cmd,
  input  logic [7:0] host_wdata,
  input  logic       take,
  input  logic       ob_load,
  input  logic [7:0] ob_byte,
  input  logic       sys_flag,
  output logic       ibf,
  output logic [7:0] ib_byte,
  output logic       ib_is_cmd,
  output logic       obf,
  output logic [7:0] host_rdata
);

  logic [7:0] ob_q;

  // Input buffer: a host write wins over the engine's take in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ibf       <= 1'b0;
      ib_byte   <= 8'h00;
      ib_is_cmd <= 1'b0;
    end else if (host_wr) begin
      ibf       <= 1'b1;
      ib_byte   <= host_wdata;
      ib_is_cmd <= host_sel_cmd;
    end else if (take) begin
      ibf <= 1'b0;
    end
  end

  // Output buffer: a new result wins over a host read in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      obf  <= 1'b0;
      ob_q <= 8'h00;
    end else if (ob_load) begin
      obf  <= 1'b1;
      ob_q <= ob_byte;
    end else if (host_rd && !host_sel_cmd) begin
      obf <= 1'b0;
    end
  end

  assign host_rdata = host_sel_cmd ? status_compose(ib_is_cmd, sys_flag, ibf, obf) : ob_q;

  AST_OBF_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ob_load |=> obf); // R3
  AST_LAST_PORT_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> (ib_is_cmd == $past(host_sel_cmd))); // R2
  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_sel_cmd && !ob_load) |=> !obf); // R3

endmodule

// File: rtl/kbc_pulse_timer.sv
module kbc_pulse_timer #(
  parameter int PULSE_CYCLES = 300
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [3:0] mask_in,
  output logic       busy,
  output logic [3:0] low_mask
);

  localparam int CW = $clog2(PULSE_CYCLES + 1);

  logic [CW-1:0] cnt;
  logic [3:0]    mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      mask_q <= 4'h0;
    end else if (start) begin
      cnt    <= CW'(PULSE_CYCLES);
      mask_q <= mask_in;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign busy     = (cnt != '0);
  assign low_mask = busy ? mask_q : 4'h0;

  AST_PULSE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy); // R10
  AST_PULSE_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start); // R11

endmodule

// File: rtl/kbc_cmd_core.sv
module kbc_cmd_core
  import kbc_pkg::*;
#(
  parameter int         RAM_DEPTH  = 32,
  parameter logic [7:0] CFG_RESET  = 8'h00,
  parameter logic [7:0] PORT_RESET = 8'h01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ibf,
  input  logic [7:0] ib_byte,
  input  logic       ib_is_cmd,
  input  logic       pulse_busy,
  input  logic [7:0] in_port,
  input  logic       selftest_ok,
  input  logic [2:0] kbd_link_code,
  input  logic [2:0] aux_link_code,
  output logic       take,
  output logic       ob_load,
  output logic [7:0] ob_byte,
  output logic       pulse_start,
  output logic [3:0] pulse_mask,
  output logic [7:0] port_reg,
  output logic [7:0] cfg_byte,
  output logic       kbd_tx_valid,
  output logic [7:0] kbd_tx_data
);

  localparam int AW = $clog2(RAM_DEPTH);

  logic [7:0]  ram [RAM_DEPTH];
  eng_state_e  state;
  logic [AW-1:0] arg_addr;
  op_class_e   cls;
  logic [AW-1:0] op_addr;
  logic        take_cmd;
  logic        take_data;

  always_comb begin
    cls       = classify_op(ib_byte);
    op_addr   = ib_byte[AW-1:0];
    take      = ibf && !pulse_busy;
    take_cmd  = take && ib_is_cmd;
    take_data = take && !ib_is_cmd;
  end

  // Result selection for opcodes that answer through the output buffer.
  always_comb begin
    ob_load = 1'b0;
    ob_byte = 8'h00;
    if (take_cmd) begin
      unique case (cls)
        OP_RD_RAM:    begin ob_load = 1'b1; ob_byte = ram[op_addr]; end
        OP_SELF_TEST: begin ob_load = 1'b1; ob_byte = selftest_code(selftest_ok); end
        OP_KBD_TEST:  begin ob_load = 1'b1; ob_byte = {5'b00000, kbd_link_code}; end
        OP_AUX_TEST:  begin ob_load = 1'b1; ob_byte = {5'b00000, aux_link_code}; end
        OP_RD_IN:     begin ob_load = 1'b1; ob_byte = in_port; end
        OP_RD_OUT:    begin ob_load = 1'b1; ob_byte = port_reg; end
        default:      ;
      endcase
    end
  end

  assign pulse_start  = take_cmd && (cls == OP_PULSE);
  assign pulse_mask   = pulse_mask_of(ib_byte);
  assign kbd_tx_valid = take_data && (state == ENG_IDLE);
  assign kbd_tx_data  = ib_byte;
  assign cfg_byte     = ram[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ENG_IDLE;
      arg_addr <= '0;
      port_reg <= PORT_RESET;
      for (int i = 0; i < RAM_DEPTH; i++) begin
        ram[i] <= (i == 0) ? CFG_RESET : 8'h00;
      end
    end else if (take_cmd) begin
      state <= ENG_IDLE;
      unique case (cls)
        OP_WR_RAM:   begin state <= ENG_RAM_ARG; arg_addr <= op_addr; end
        OP_WR_OUT:   state <= ENG_PORT_ARG;
        OP_PORT_NIB: port_reg[3:0] <= ib_byte[3:0];
        OP_A20_OFF:  port_reg[PORT_A20_BIT] <= 1'b0;
        OP_A20_ON:   port_reg[PORT_A20_BIT] <= 1'b1;
        OP_KBD_OFF:  ram[0][CFG_KBD_BIT] <= 1'b1;
        OP_KBD_ON:   ram[0][CFG_KBD_BIT] <= 1'b0;
        OP_AUX_OFF:  ram[0][CFG_AUX_BIT] <= 1'b1;
        OP_AUX_ON:   ram[0][CFG_AUX_BIT] <= 1'b0;
        default:     ;
      endcase
    end else if (take_data) begin
      state <= ENG_IDLE;
      unique case (state)
        ENG_RAM_ARG:  ram[arg_addr] <= ib_byte;
        ENG_PORT_ARG: port_reg <= ib_byte;
        default:      ;
      endcase
    end
  end

  AST_A20_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ib_is_cmd && ib_byte == 8'hDD) |=> !port_reg[1]); // R6
  AST_ARG_NOT_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ib_is_cmd && (ib_byte[7:5] == 3'b011 || ib_byte == 8'hD1)) |=> !kbd_tx_valid); // R12

endmodule

// File: rtl/kbc_cmd_engine.sv
module kbc_cmd_engine
  import kbc_pkg::*;
#(
  parameter int         PULSE_CYCLES = 300,
  parameter int         RAM_DEPTH    = 32,
  parameter logic [7:0] CFG_RESET    = 8'h00,
  parameter logic [7:0] PORT_RESET   = 8'h01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic       host_sel_cmd,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic [7:0] in_port,
  input  logic       selftest_ok,
  input  logic [2:0] kbd_link_code,
  input  logic [2:0] aux_link_code,
  output logic [7:0] sys_port,
  output logic       kbd_disabled,
  output logic       aux_disabled,
  output logic       kbd_tx_valid,
  output logic [7:0] kbd_tx_data
);

  logic       ibf, obf, ib_is_cmd, eng_take, ob_load, pulse_start, pulse_busy;
  logic [7:0] ib_byte, ob_byte, port_reg, cfg_byte;
  logic [3:0] pulse_mask, low_mask;

  kbc_host_if u_host (
    .clk(clk), .rst_n(rst_n),
    .host_wr(host_wr), .host_rd(host_rd), .host_sel_cmd(host_sel_cmd),
    .host_wdata(host_wdata),
    .take(eng_take), .ob_load(ob_load), .ob_byte(ob_byte),
    .sys_flag(cfg_byte[CFG_SYS_BIT]),
    .ibf(ibf), .ib_byte(ib_byte), .ib_is_cmd(ib_is_cmd), .obf(obf),
    .host_rdata(host_rdata)
  );

  kbc_cmd_core #(
    .RAM_DEPTH(RAM_DEPTH), .CFG_RESET(CFG_RESET), .PORT_RESET(PORT_RESET)
  ) u_core (
    .clk(clk), .rst_n(rst_n),
    .ibf(ibf), .ib_byte(ib_byte), .ib_is_cmd(ib_is_cmd),
    .pulse_busy(pulse_busy),
    .in_port(in_port), .selftest_ok(selftest_ok),
    .kbd_link_code(kbd_link_code), .aux_link_code(aux_link_code),
    .take(eng_take), .ob_load(ob_load), .ob_byte(ob_byte),
    .pulse_start(pulse_start), .pulse_mask(pulse_mask),
    .port_reg(port_reg), .cfg_byte(cfg_byte),
    .kbd_tx_valid(kbd_tx_valid), .kbd_tx_data(kbd_tx_data)
  );

  kbc_pulse_timer #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk(clk), .rst_n(rst_n),
    .start(pulse_start), .mask_in(pulse_mask),
    .busy(pulse_busy), .low_mask(low_mask)
  );

  assign sys_port     = port_reg & ~{4'b0000, low_mask};
  assign kbd_disabled = cfg_byte[CFG_KBD_BIT];
  assign aux_disabled = cfg_byte[CFG_AUX_BIT];

  AST_IBF_HELD_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (ibf && pulse_busy) |=> ibf); // R11
  AST_IBF_CLEARS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (ibf && !pulse_busy && !host_wr) |=> !ibf); // R2
  AST_PORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!eng_take && !pulse_busy) |=> $stable(sys_port)); // R6

endmodule

// File: tb/kbc_cmd_engine_tb_top.sv
module kbc_cmd_engine_tb_top;

  localparam int TCK = 10;
  localparam int PULSE = 300;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0, host_rd = 1'b0, host_sel_cmd = 1'b1;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic [7:0] in_port = 8'h00;
  logic       selftest_ok = 1'b1;
  logic [2:0] kbd_link_code = 3'd0, aux_link_code = 3'd0;
  logic [7:0] sys_port;
  logic       kbd_disabled, aux_disabled, kbd_tx_valid;
  logic [7:0] kbd_tx_data;

  int checks = 0;
  int fails = 0;
  int tx_count = 0;
  logic [7:0] tx_last = 8'h00;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         done = 0;

  always #(TCK/2) clk = ~clk;

  kbc_cmd_engine #(.PULSE_CYCLES(PULSE)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_wr(host_wr), .host_rd(host_rd), .host_sel_cmd(host_sel_cmd),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .in_port(in_port), .selftest_ok(selftest_ok),
    .kbd_link_code(kbd_link_code), .aux_link_code(aux_link_code),
    .sys_port(sys_port), .kbd_disabled(kbd_disabled), .aux_disabled(aux_disabled),
    .kbd_tx_valid(kbd_tx_valid), .kbd_tx_data(kbd_tx_data)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // Monitor: scoreboard pops one expected byte per data-address read.
  always @(negedge clk) begin
    #(TCK/4);
    if (host_rd && !host_sel_cmd) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL scoreboard: actual %02h expected none", host_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (host_rdata !== e) begin
          fails++;
          $display("FAIL %s: actual %02h expected %02h", t, host_rdata, e);
        end
      end
    end
    if (kbd_tx_valid) begin
      tx_count++;
      tx_last = kbd_tx_data;
    end
  end

  task automatic host_write(input logic sel, input logic [7:0] b);
    @(negedge clk);
    host_sel_cmd = sel; host_wdata = b; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; host_sel_cmd = 1'b1;
  endtask

  task automatic wr_cmd(input logic [7:0] b); host_write(1'b1, b); endtask
  task automatic wr_data(input logic [7:0] b); host_write(1'b0, b); endtask

  function automatic logic [7:0] status_now();
    return host_rdata;
  endfunction

  task automatic wait_idle();
    @(negedge clk); #1;
    while (status_now()[1] == 1'b1) begin @(negedge clk); #1; end
  endtask

  task automatic expect_result(input logic [7:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    wait_idle();
    while (status_now()[0] == 1'b0) begin @(negedge clk); #1; end
    @(negedge clk);
    host_sel_cmd = 1'b0; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0; host_sel_cmd = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int lows;
    int tx_before;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    check("R1 status", status_now(), 8'h00);
    check("R1 sys_port", sys_port, 8'h01);
    check("R1 disables", {6'b0, kbd_disabled, aux_disabled}, 8'h00);
    check("R1 tx", {7'b0, kbd_tx_valid}, 8'h00);

    // R2 IBF and last-port bit
    wr_cmd(8'hA8); #1;
    check("R2 ibf set cmd", status_now() & 8'h0A, 8'h0A);
    @(negedge clk); #1;
    check("R2 ibf clear", status_now() & 8'h02, 8'h00);

    // R4 RAM write of config byte, argument not forwarded (R12)
    tx_before = tx_count;
    wr_cmd(8'h60);
    wr_data(8'h44); #1;
    check("R2 last port data", status_now() & 8'h08, 8'h00);
    wait_idle();
    check("R4 sys flag", status_now() & 8'h04, 8'h04);
    check("R12 arg not sent", 8'(tx_count - tx_before), 8'h00);
    wr_cmd(8'h20); expect_result(8'h44, "R3 cfg read");
    check("R3 obf cleared", status_now() & 8'h01, 8'h00);
    wr_cmd(8'h65); wr_data(8'hA5);
    wr_cmd(8'h25); expect_result(8'hA5, "R4 ram addr5");
    wr_cmd(8'h3F); expect_result(8'h00, "R3 ram addr31");
    wr_cmd(8'h20); expect_result(8'h44, "R4 cfg untouched");

    // R8 configuration bits
    wr_cmd(8'hAD); wait_idle();
    check("R8 kbd off", {7'b0, kbd_disabled}, 8'h01);
    wr_cmd(8'h20); expect_result(8'h54, "R8 cfg bit4");
    wr_cmd(8'hAE); wait_idle();
    check("R8 kbd on", {7'b0, kbd_disabled}, 8'h00);
    wr_cmd(8'hA7); wait_idle();
    check("R8 aux off", {7'b0, aux_disabled}, 8'h01);
    wr_cmd(8'h20); expect_result(8'h64, "R8 cfg bit5");
    wr_cmd(8'hA8); wait_idle();
    check("R8 aux on", {7'b0, aux_disabled}, 8'h00);

    // R5 / R6 output port
    wr_cmd(8'h60); wr_data(8'h00); wait_idle();
    check("R4 sys flag clear", status_now() & 8'h04, 8'h00);
    wr_cmd(8'h9A); wait_idle();
    check("R5 nibble", sys_port, 8'h0A);
    wr_cmd(8'hD1); wr_data(8'hC3); wait_idle();
    check("R6 port write", sys_port, 8'hC3);
    wr_cmd(8'h95); wait_idle();
    check("R5 upper kept", sys_port, 8'hC5);
    wr_cmd(8'hD0); expect_result(8'hC5, "R6 port read");
    wr_cmd(8'hDF); wait_idle();
    check("R6 a20 on", sys_port, 8'hC7);
    wr_cmd(8'hDD); wait_idle();
    check("R6 a20 off", sys_port, 8'hC5);
    wr_cmd(8'hD1); wr_data(8'h03); wait_idle();

    // R9 input port, R7 self-tests
    in_port = 8'h9C;
    wr_cmd(8'hC0); expect_result(8'h9C, "R9 in port");
    wr_cmd(8'hAA); expect_result(8'h55, "R7 self pass");
    selftest_ok = 1'b0;
    wr_cmd(8'hAA); expect_result(8'hFC, "R7 self fail");
    selftest_ok = 1'b1;
    kbd_link_code = 3'd3;
    wr_cmd(8'hAB); expect_result(8'h03, "R7 kbd link");
    aux_link_code = 3'd4;
    wr_cmd(8'hA9); expect_result(8'h04, "R7 aux link");

    // R10 reset pulse width
    wr_cmd(8'hFE);
    lows = 0;
    @(negedge clk); #1;
    check("R10 pulse value", sys_port, 8'h02);
    while (sys_port[0] == 1'b0 && lows < 2 * PULSE) begin
      lows++; @(negedge clk); #1;
    end
    check("R10 pulse width", 8'(lows == PULSE), 8'h01);
    check("R10 restored", sys_port, 8'h03);
    wait_idle();
    wr_cmd(8'hF5); @(negedge clk); #1;
    check("R10 mask bits1,3", sys_port, 8'h01);
    wait_idle();
    repeat (PULSE + 2) @(negedge clk); #1;
    check("R10 restored2", sys_port, 8'h03);

    // R11 command held during pulse
    wr_cmd(8'hFC);
    wr_cmd(8'hAA); #1;
    check("R11 pulse low", sys_port, 8'h00);
    check("R11 ibf held", status_now() & 8'h03, 8'h02);
    repeat (PULSE / 2) @(negedge clk); #1;
    check("R11 ibf still held", status_now() & 8'h03, 8'h02);
    expect_result(8'h55, "R11 deferred cmd");
    check("R11 port restored", sys_port, 8'h03);

    // R12 keyboard-bound data
    tx_before = tx_count;
    wr_data(8'h5A); wait_idle();
    @(negedge clk);
    check("R12 tx count", 8'(tx_count - tx_before), 8'h01);
    check("R12 tx data", tx_last, 8'h5A);

    check("scoreboard drained", 8'(exp_q.size()), 8'h00);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule